// File: doc/BRIEF.md
# Supervisory Reset and Power-Fail Warning Generator

This block drives an active-low processor reset and an active-low power-fail warning from digital supervisory flags. Its inputs are already-compared flags: supply below the warning threshold, supply below the minimum operating level, and the result of an auxiliary undervoltage comparator. A fourth input is an asynchronous, active-low manual reset pin. Both outputs are plain registered logic levels. Any open-drain driver is added outside the block.

A single recovery counter sets how long reset stays low after the supply comes back. The same counter serves a qualified manual reset, so both causes give the same reset duration. The manual pin goes through a synchronizer and then a minimum-width filter, so short glitches never reach the counter.

The warning output normally reports the auxiliary comparator. When the supply is below the minimum level, the output is pulled low. During the recovery window that follows a supply return, the output is held high.

Top module: `supv_reset_pfo`

## Requirements
- R1: While `rst` is high, `rst_n_o` is 0 and `pfw_n_o` is 1. A release of `rst` is treated as a power-up: `rst_n_o` rises at the RECOV_CYC-th clock edge after `rst` is sampled low.
- R2: When `vlow_i` is sampled high on an edge, `rst_n_o` is 0 after that edge and stays 0 for as long as `vlow_i` stays high.
- R3: After `vlow_i` goes low, with no manual reset, `rst_n_o` stays 0 and rises at the RECOV_CYC-th edge that samples `vlow_i` low.
- R4: Consider a low level on `mr_n_i` that is sampled on at least MIN_PULSE_CYC consecutive edges. It drives `rst_n_o` to 0. `rst_n_o` then rises RECOV_CYC+SYNC_STAGES+1 edges after the first edge that samples `mr_n_i` high again.
- R5: A low level on `mr_n_i` sampled on fewer than MIN_PULSE_CYC consecutive edges leaves `rst_n_o` at 1.
- R6: A qualified manual reset that arrives while the recovery count is running restarts the count. The reset release then follows the R4 timing from the end of the manual pulse.
- R7: While `rst_n_o` is 1 and `vdead_i` is 0, `pfw_n_o` one edge later equals the inverse of `pfcmp_low_i`. A value of 1 on `pfcmp_low_i` means the monitored level is below its threshold.
- R8: When `vdead_i` is sampled high, `pfw_n_o` is 0 after that edge, whatever `pfcmp_low_i` is.
- R9: After a supply return, `pfw_n_o` is held at 1 whatever `pfcmp_low_i` is. The hold runs from the first edge that samples `vlow_i` low up to and including the edge where `rst_n_o` rises. This holds even if a manual reset restarts the count. A manual reset from normal running does not hold `pfw_n_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset, treated as a power-up |
| vlow_i | input | 1 | Supply is below the warning threshold |
| vdead_i | input | 1 | Supply is below the minimum level (backup operation) |
| pfcmp_low_i | input | 1 | Auxiliary comparator reports a level below its threshold |
| mr_n_i | input | 1 | Asynchronous active-low manual reset request |
| rst_n_o | output | 1 | Active-low processor reset level |
| pfw_n_o | output | 1 | Active-low power-fail warning level |

## Verification
The bench aims at the pulse-width boundary. A manual pulse exactly MIN_PULSE_CYC edges long must reset, and one a single edge shorter must not. An off-by-one filter would either let glitches through or swallow legitimate requests.

The bench measures the exact release edge after a supply return, after a manual pulse and after a block reset. A counter that reloads wrongly would release reset one cycle early or late.

It also restarts the recovery count with a manual pulse in the middle of a power-return window. A design that forgot the restart would release early. A design that dropped the blanking tag on the restart would let the warning output follow the comparator too soon. Finally, it checks that a reset from normal running does not blank the warning output.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // Recovery phase of the reset sequencer; PH_PWR also blanks the warning output
  typedef enum logic [1:0] {
    PH_RUN = 2'd0,
    PH_PWR = 2'd1,
    PH_MAN = 2'd2
  } phase_e;
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= {STAGES{RST_VAL}};
    else     sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/supv_mr_qual.sv
module supv_mr_qual #(
  parameter int MIN_PULSE_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic mr_s_n_i,
  output logic mr_act_o
);
  localparam int W = $clog2(MIN_PULSE_CYC + 1);
  localparam logic [W-1:0] LAST = W'(MIN_PULSE_CYC - 1);

  logic [W-1:0] lo_cnt_q;
  logic         act_q;

  // Consecutive-low counter; any high sample clears it and drops the request
  always_ff @(posedge clk) begin
    if (rst || mr_s_n_i) begin
      lo_cnt_q <= '0;
      act_q    <= 1'b0;
    end else if (lo_cnt_q == LAST) begin
      act_q    <= 1'b1;
    end else begin
      lo_cnt_q <= lo_cnt_q + 1'b1;
    end
  end

  assign mr_act_o = act_q;
endmodule

// File: rtl/supv_recov.sv
module supv_recov
  import supv_pkg::*;
#(
  parameter int RECOV_CYC = 5_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic vlow_i,
  input  logic mr_act_i,
  output logic rst_n_o,
  output logic blank_o
);
  localparam int CW = $clog2(RECOV_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RECOV_CYC - 1);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || vlow_i) begin
      ph_q  <= PH_PWR;
      cnt_q <= '0;
    end else if (mr_act_i) begin
      // restart; a power-return window keeps its blanking tag
      if (ph_q == PH_RUN) ph_q <= PH_MAN;
      cnt_q <= '0;
    end else if (ph_q != PH_RUN) begin
      if (cnt_q == LAST) begin
        ph_q  <= PH_RUN;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_n_o = (ph_q == PH_RUN);
  assign blank_o = (ph_q == PH_PWR);
endmodule

// File: rtl/supv_pfw.sv
module supv_pfw (
  input  logic clk,
  input  logic rst,
  input  logic vdead_i,
  input  logic vlow_i,
  input  logic blank_i,
  input  logic cmp_low_i,
  output logic pfw_n_o
);
  logic pfw_q;

  always_ff @(posedge clk) begin
    if (rst)                     pfw_q <= 1'b1;
    else if (vdead_i)            pfw_q <= 1'b0;
    else if (blank_i && !vlow_i) pfw_q <= 1'b1;
    else                         pfw_q <= ~cmp_low_i;
  end

  assign pfw_n_o = pfw_q;
endmodule

// File: rtl/supv_reset_pfo.sv
module supv_reset_pfo #(
  parameter int RECOV_CYC     = 5_000_000,
  parameter int MIN_PULSE_CYC = 25,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic vlow_i,
  input  logic vdead_i,
  input  logic pfcmp_low_i,
  input  logic mr_n_i,
  output logic rst_n_o,
  output logic pfw_n_o
);
  logic mr_s_n;
  logic mr_act;
  logic blank;

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_i(mr_n_i), .q_o(mr_s_n)
  );

  supv_mr_qual #(.MIN_PULSE_CYC(MIN_PULSE_CYC)) u_qual (
    .clk(clk), .rst(rst), .mr_s_n_i(mr_s_n), .mr_act_o(mr_act)
  );

  supv_recov #(.RECOV_CYC(RECOV_CYC)) u_recov (
    .clk(clk), .rst(rst), .vlow_i(vlow_i), .mr_act_i(mr_act),
    .rst_n_o(rst_n_o), .blank_o(blank)
  );

  supv_pfw u_pfw (
    .clk(clk), .rst(rst), .vdead_i(vdead_i), .vlow_i(vlow_i),
    .blank_i(blank), .cmp_low_i(pfcmp_low_i), .pfw_n_o(pfw_n_o)
  );
endmodule

// File: rtl/supv_reset_pfo_chk.sv
module supv_reset_pfo_chk (
  input logic clk,
  input logic rst,
  input logic vlow_i,
  input logic vdead_i,
  input logic pfcmp_low_i,
  input logic rst_n_o,
  input logic pfw_n_o
);
  // R2
  low_supply_holds_reset_chk: assert property (@(posedge clk) disable iff (rst)
    vlow_i |=> !rst_n_o);

  // R3
  release_needs_supply_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> !$past(vlow_i));

  // R7
  warn_follows_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_n_o && !vdead_i) |=> (pfw_n_o == !$past(pfcmp_low_i)));

  // R8
  backup_forces_warn_chk: assert property (@(posedge clk) disable iff (rst)
    vdead_i |=> !pfw_n_o);

  // R9
  return_blanks_warn_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(vlow_i) && !vdead_i) |=> pfw_n_o);
endmodule

bind supv_reset_pfo supv_reset_pfo_chk chk_i (.*);

// File: tb/supv_reset_pfo_tb_top.sv
module supv_reset_pfo_tb_top;
  localparam int RC = 20;
  localparam int MP = 4;
  localparam int SS = 2;

  // vector columns: {vdead, pfcmp_low, expected pfw_n}
  localparam logic [2:0] VT [8] = '{3'b001, 3'b010, 3'b100, 3'b001,
                                    3'b110, 3'b010, 3'b001, 3'b100};

  logic clk = 1'b0, rst = 1'b1, vlow = 1'b0, vdead = 1'b0, cmp = 1'b0, mr_n = 1'b1;
  logic rst_n, pfw_n;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  supv_reset_pfo #(.RECOV_CYC(RC), .MIN_PULSE_CYC(MP), .SYNC_STAGES(SS)) dut_i (
    .clk(clk), .rst(rst), .vlow_i(vlow), .vdead_i(vdead), .pfcmp_low_i(cmp),
    .mr_n_i(mr_n), .rst_n_o(rst_n), .pfw_n_o(pfw_n)
  );

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (rst_n !== 1'b1 && n < 1000) begin step(); n++; end
  endtask

  task automatic pulse(input int p);
    mr_n = 1'b0;
    step(p);
    mr_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    int lows;
    step(3);
    chk("R1 reset level", rst_n, 1'b0);
    chk("R1 warn level", pfw_n, 1'b1);
    rst = 1'b0;
    wait_rise(n);
    chk_int("R1 power-up release edge", n, RC);

    // table walk in normal running
    step();
    for (int i = 0; i < 8; i++) begin
      vdead = VT[i][2];
      cmp   = VT[i][1];
      step();
      chk(VT[i][2] ? "R8 backup vector" : "R7 follow vector", pfw_n, VT[i][0]);
    end
    vdead = 1'b0; cmp = 1'b0;
    step();

    // R2 supply drop
    vlow = 1'b1;
    step();
    chk("R2 reset on drop", rst_n, 1'b0);
    step(5);
    chk("R2 reset held", rst_n, 1'b0);
    vdead = 1'b1;
    step();
    chk("R8 backup forces warn low", pfw_n, 1'b0);

    // R3 and R9 supply return with comparator low
    vdead = 1'b0; vlow = 1'b0; cmp = 1'b1;
    step(RC - 1);
    chk("R3 still in reset", rst_n, 1'b0);
    chk("R9 blanked during recovery", pfw_n, 1'b1);
    step();
    chk("R3 release edge", rst_n, 1'b1);
    chk("R9 blanked at release edge", pfw_n, 1'b1);
    step();
    chk("R9 follows after window", pfw_n, 1'b0);

    // R6 manual restart during power-return window
    cmp = 1'b0;
    vlow = 1'b1;
    step(2);
    vlow = 1'b0;
    cmp = 1'b1;
    step(8);
    pulse(MP + 2);
    wait_rise(n);
    chk_int("R6 restarted release", n, RC + SS + 1);
    chk("R9 blank kept through restart", pfw_n, 1'b1);
    step();
    chk("R9 follows after restarted window", pfw_n, 1'b0);

    // R4 boundary-width pulse from running, comparator low
    pulse(MP);
    step(SS + 1);
    chk("R4 reset asserted", rst_n, 1'b0);
    chk("R9 manual reset not blanked", pfw_n, 1'b0);
    wait_rise(n);
    chk_int("R4 release edge", n, RC - 1 + 1);
    cmp = 1'b0;
    step();

    // R5 glitch rejection
    pulse(MP - 1);
    lows = 0;
    for (int k = 0; k < 40; k++) begin step(); if (rst_n !== 1'b1) lows++; end
    chk_int("R5 one-short pulse ignored", lows, 0);
    pulse(1);
    lows = 0;
    for (int k = 0; k < 40; k++) begin step(); if (rst_n !== 1'b1) lows++; end
    chk_int("R5 single-cycle glitch ignored", lows, 0);

    // R1 block reset mid-run
    rst = 1'b1;
    cmp = 1'b1;
    step();
    chk("R1 reset mid-run", rst_n, 1'b0);
    chk("R1 warn high in reset", pfw_n, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule